// File: doc/BRIEF.md
# Global-History Concatenated Branch Predictor

This block predicts whether a conditional branch is taken. It keeps a table of 2-bit saturating counters and a global history register that holds the outcomes of the most recent branches. The table index places the history bits in the upper part. The lower part holds branch-address bits, taken after the always-zero alignment bits are dropped. A lower counter value means a stronger not-taken bias and a higher value a stronger taken bias.

Each request carries the branch address and its actual outcome, so one accepted request does several things in the same step. It reads the prediction, compares it with the outcome, moves the indexed counter one step towards the outcome and shifts the outcome into the history. The prediction and the mispredict flag appear one cycle later, together with a running mispredict total. After reset the block clears the table one entry per cycle and holds `req_ready` low until the walk is done.

The default geometry is 5 history bits and 5 address bits. The production setting of 7 and 7 (2^14 counters) is reached through the parameters.

Top module: `gh_branch_predictor`

## Requirements
- R1: While `rst_n` is low, `req_ready`, `resp_valid` and `miss_count` are 0. After reset is released, `req_ready` stays low for exactly 2^(HIST_W+ADDR_IDX_W) clock edges and then goes high. `req_ready` is high in the first cycle after that many edges.
- R2: After the clearing walk every counter holds 0, so a branch whose counter has not been touched is predicted not-taken.
- R3: The counter index is {history[HIST_W-1:0], req_pc[ALIGN_DROP+ADDR_IDX_W-1:ALIGN_DROP]}, with the history in the upper bits. Address bits below ALIGN_DROP and above the selected field have no effect on which counter is used.
- R4: The prediction (`resp_pred`, 1 = taken) is 1 exactly when the indexed counter holds 2 or 3.
- R5: A taken outcome raises the indexed counter by one, and the counter stays at 3 once it is there. A not-taken outcome lowers it by one, and it stays at 0 once it is there.
- R6: Each accepted request shifts the history left by one and puts the outcome (1 = taken) into bit 0. The history is cleared by reset.
- R7: `resp_mispredict` is 1 exactly when the prediction differs from the actual outcome.
- R8: `resp_valid` is high in the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge) and low otherwise.
- R9: `miss_count` rises by one for each mispredicted request, visible together with its response. It stops at 2^MISS_W-1.
- R10: The prediction, the mispredict flag and the index are formed from the counter and history values before the request's own update. This holds for back-to-back requests to the same counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (low during table clearing) |
| req_pc | input | PC_W | Branch instruction address |
| req_taken | input | 1 | Actual outcome, 1 = taken |
| resp_valid | output | 1 | Response present, one cycle after acceptance |
| resp_pred | output | 1 | Prediction made for the request, 1 = taken |
| resp_mispredict | output | 1 | Prediction differed from outcome |
| miss_count | output | MISS_W | Saturating count of mispredicts |

## Verification
The bench trains one address until the history is all ones, so the same counter is hit back to back. A design that updated before reading, or that did not saturate at 3, would give a different prediction or mispredict flag after the outcome turns. Addresses that differ only in the alignment bits or above the index field are sent against a trained counter, and a design that slices the wrong address bits would predict not-taken there. Outcome patterns such as alternating and runs of three are used to expose a history that shifts the wrong way or that puts the outcome in the wrong bit. The mispredict total is driven past its limit with a narrow counter, to catch wrap-around, and the length of the reset walk is timed edge by edge.

// File: rtl/bp_pkg.sv
// Package: shared counter type and counter update rules for the predictor.
// Assumes: 2-bit counters where value 2 or 3 means "predict taken".
package bp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_MAX = 2'd3;
    localparam ctr2_t CTR_MIN = 2'd0;

    // Next counter value after an outcome, saturating at both ends.
    function automatic ctr2_t ctr_next(input ctr2_t cur, input logic taken);
        ctr2_t nxt;
        if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : ctr2_t'(cur + 2'd1);
        else       nxt = (cur == CTR_MIN) ? CTR_MIN : ctr2_t'(cur - 2'd1);
        return nxt;
    endfunction

    // Direction implied by a counter value.
    function automatic logic ctr_taken(input ctr2_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_index_gen.sv
// Module: forms the table index from global history (upper) and branch
// address bits (lower), after dropping the always-zero alignment bits.
// Assumes: PC_W >= ALIGN_DROP + ADDR_IDX_W.
module bp_index_gen #(
    parameter int PC_W       = 32,
    parameter int HIST_W     = 5,
    parameter int ADDR_IDX_W = 5,
    parameter int ALIGN_DROP = 2,
    localparam int IDX_W     = HIST_W + ADDR_IDX_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    // Concatenate history above the selected address field.
    always_comb begin
        idx = {hist, pc[ALIGN_DROP +: ADDR_IDX_W]};
    end

endmodule

// File: rtl/bp_ctr_table.sv
// Module: table of 2-bit counters with one combinational read port and one
// write port. After reset it clears one entry per cycle and reports busy
// until the whole table has been cleared.
// Assumes: the caller does not write while busy is high.
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr2_t            wr_val,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    ctr2_t            mem [DEPTH];
    logic [IDX_W-1:0] clr_ptr;

    // Clearing walk: pointer and busy flag, restarted by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b1;
            clr_ptr <= '0;
        end else if (busy) begin
            clr_ptr <= clr_ptr + 1'b1;
            if (clr_ptr == LAST_IDX) busy <= 1'b0;
        end
    end

    // Storage write: clearing entries first, otherwise the update from the caller.
    always_ff @(posedge clk) begin
        if (rst_n && busy)  mem[clr_ptr] <= CTR_MIN;
        else if (rst_n && wr_en) mem[wr_idx] <= wr_val;
    end

    // Read port: current stored value, before any write at this edge.
    always_comb begin
        rd_val = mem[rd_idx];
    end

    // The walk does not end early: busy persists until the last entry is cleared.
    assert_walk_complete_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && clr_ptr != LAST_IDX) |=> busy);

    // Once cleared, the table stays out of the walk until the next reset.
    assert_walk_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

endmodule

// File: rtl/bp_sat_counter.sv
// Module: event counter that stops at its all-ones value.
// Assumes: at most one event per cycle.
module bp_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    // Count events, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP));

    assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != TOP) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/gh_branch_predictor.sv
// Module: global-history conditional branch predictor. One accepted request
// reads the prediction, resolves it against the supplied outcome, updates
// the counter and shifts the history. The response is registered one cycle later.
// Assumes: requests arrive in program order with the actual outcome attached.
module gh_branch_predictor
    import bp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int HIST_W     = 5,
    parameter int ADDR_IDX_W = 5,
    parameter int ALIGN_DROP = 2,
    parameter int MISS_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PC_W-1:0]   req_pc,
    input  logic              req_taken,
    output logic              resp_valid,
    output logic              resp_pred,
    output logic              resp_mispredict,
    output logic [MISS_W-1:0] miss_count
);

    localparam int IDX_W = HIST_W + ADDR_IDX_W;

    logic [HIST_W-1:0] hist;
    logic [IDX_W-1:0]  idx;
    ctr2_t             cur_ctr;
    logic              table_busy;
    logic              accept;
    logic              pred_now;
    logic              miss_now;

    bp_index_gen #(
        .PC_W(PC_W), .HIST_W(HIST_W), .ADDR_IDX_W(ADDR_IDX_W), .ALIGN_DROP(ALIGN_DROP)
    ) u_index (
        .pc(req_pc), .hist(hist), .idx(idx)
    );

    bp_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx), .rd_val(cur_ctr),
        .wr_en(accept), .wr_idx(idx), .wr_val(ctr_next(cur_ctr, req_taken)),
        .busy(table_busy)
    );

    bp_sat_counter #(.W(MISS_W)) u_miss (
        .clk(clk), .rst_n(rst_n), .inc(miss_now), .count(miss_count)
    );

    // Handshake and resolution from the pre-update counter value.
    always_comb begin
        req_ready = rst_n && !table_busy;
        accept    = req_valid && req_ready;
        pred_now  = ctr_taken(cur_ctr);
        miss_now  = accept && (pred_now != req_taken);
    end

    // Global history: shift in each accepted outcome at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      hist <= '0;
        else if (accept) hist <= {hist[HIST_W-2:0], req_taken};
    end

    // Registered response for the request accepted at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid      <= 1'b0;
            resp_pred       <= 1'b0;
            resp_mispredict <= 1'b0;
        end else begin
            resp_valid      <= accept;
            resp_pred       <= accept && pred_now;
            resp_mispredict <= miss_now;
        end
    end

    assert_resp_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    assert_no_resp_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid);

    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (hist == {$past(hist[HIST_W-2:0]), $past(req_taken)}));

    assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(hist));

    assert_miss_count_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_mispredict) |-> $stable(miss_count));

endmodule

// File: tb/sim_gh_branch_predictor.sv
`timescale 1ns/1ps
// Directed bench: a reference model built from the requirements predicts every response.
module sim_gh_branch_predictor;

    localparam int PC_W = 32, HW = 5, AW = 5, AD = 2, MW = 4;
    localparam int DEPTH = 1 << (HW + AW);
    localparam int MISS_TOP = (1 << MW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, req_taken = 1'b0;
    logic [PC_W-1:0] req_pc = '0;
    logic req_ready, resp_valid, resp_pred, resp_mispredict;
    logic [MW-1:0] miss_count;

    int n_checks = 0, n_fails = 0;
    logic [1:0] m_ctr [DEPTH];
    logic [HW-1:0] m_hist;
    int m_miss;

    gh_branch_predictor #(.PC_W(PC_W), .HIST_W(HW), .ADDR_IDX_W(AW), .ALIGN_DROP(AD), .MISS_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pc(req_pc), .req_taken(req_taken), .resp_valid(resp_valid),
        .resp_pred(resp_pred), .resp_mispredict(resp_mispredict), .miss_count(miss_count)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // One request; the model computes the response, then the outputs are compared.
    task automatic issue(input logic [PC_W-1:0] pc, input logic tk, input string tag);
        logic [HW+AW-1:0] ix;
        logic ep, em;
        ix = {m_hist, pc[AD +: AW]};
        ep = m_ctr[ix][1];
        em = (ep != tk);
        if (tk) m_ctr[ix] = (m_ctr[ix] == 2'd3) ? 2'd3 : m_ctr[ix] + 2'd1;
        else    m_ctr[ix] = (m_ctr[ix] == 2'd0) ? 2'd0 : m_ctr[ix] - 2'd1;
        m_hist = {m_hist[HW-2:0], tk};
        if (em) m_miss++;
        req_pc = pc; req_taken = tk; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 valid"}, resp_valid, 1);
        check({tag, " R4 pred"}, resp_pred, ep);
        check({tag, " R7 mispredict"}, resp_mispredict, em);
        check({tag, " R9 count"}, miss_count, (m_miss > MISS_TOP) ? MISS_TOP : m_miss);
        req_valid = 1'b0;
    endtask

    // R1: reset state and exact length of the clearing walk.
    task automatic t_reset();
        int cyc;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", req_ready, 0);
        check("R1 resp_valid in reset", resp_valid, 0);
        check("R1 count in reset", miss_count, 0);
        for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'd0;
        m_hist = '0; m_miss = 0;
        req_valid = 1'b1;  // must be ignored while busy
        rst_n = 1'b1;
        cyc = 0;
        while (!req_ready && cyc < DEPTH + 10) begin
            @(negedge clk);
            cyc++;
            if (!req_ready) check("R1 no resp while busy", resp_valid, 0);
        end
        req_valid = 1'b0;
        check("R1 walk length", cyc, DEPTH);
    endtask

    // R2: untouched counters predict not-taken.
    task automatic t_cold();
        issue(32'h0000_1000, 1'b0, "R2 cold a");
        issue(32'h0000_1044, 1'b0, "R2 cold b");
        issue(32'h0000_107C, 1'b1, "R2 cold c");
    endtask

    // R5/R10/R3: train one address until the history is all ones, saturate, then reverse.
    task automatic t_train();
        for (int i = 0; i < 10; i++) issue(32'h0000_2010, 1'b1, "R5 R10 train");
        issue(32'h0000_2013, 1'b1, "R3 low alignment bits");
        issue(32'hABC0_2010, 1'b1, "R3 upper bits");
        issue(32'h0000_2010, 1'b0, "R5 step down");
        for (int i = 0; i < 5; i++) issue(32'h0000_2010, 1'b1, "R10 refill");
        issue(32'h0000_2010, 1'b0, "R5 from top");
    endtask

    // R6: outcome patterns that reveal shift direction and insertion bit.
    task automatic t_history();
        for (int i = 0; i < 12; i++) issue(32'h0000_3020, i[0], "R6 alternate");
        for (int i = 0; i < 12; i++) issue(32'h0000_3020, (i % 3) == 0, "R6 period three");
        for (int i = 0; i < 6; i++) issue(32'h0000_3020 + 32'(i * 4), (i % 3) == 0, "R3 R6 mixed pc");
    endtask

    // R8: idle cycles give no response.
    task automatic t_idle();
        repeat (2) begin
            @(negedge clk);
            check("R8 idle", resp_valid, 0);
        end
    endtask

    // R9: mispredict total stops at its top value.
    task automatic t_miss_sat();
        for (int i = 0; i < 30; i++) issue(32'h0000_4000, i[0], "R9 saturate");
        check("R9 at top", miss_count, MISS_TOP);
    endtask

    initial begin
        #(200000 * 5.0);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_cold();
        t_idle();
        t_train();
        t_history();
        t_idle();
        t_miss_sat();
        t_reset();
        t_cold();
        report();
    end

endmodule